// File: doc/BRIEF.md
# Out-of-Order Issue Buffer

This block sits between instruction decode and a set of functional units. It keeps up to four decoded register-to-register operations (a unit code, a destination register and two source registers) and sends one of them per cycle to its unit. The one sent is the oldest entry that is ready, not necessarily the oldest entry. An entry is ready once no older instruction still has a write pending to any of its sources and its target unit reports that it is free.

Decode offers operations on a valid/ready port. The buffer refuses an operation when it is full. It also refuses one whose destination is a source of an entry that has not yet issued (a write-after-read hazard), or whose destination already has a write pending (a write-after-write hazard). A register's pending bit is set when an operation writing it enters the buffer, not when it issues. The bit is cleared by the writeback port. Because operands are read when an entry issues, an issued operation can no longer cause a write-after-read hazard.

Back-pressure rules on the insert port: an operation transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is combinational from the current occupancy, the pending bits, the buffered sources and `in_dst`. It does not depend on `in_valid`, on dispatch in the same cycle or on writeback in the same cycle. While `in_valid` is high and `in_ready` is low, decode holds the operation and offers it again each cycle. The dispatch port has no handshake of its own: a unit accepts whenever it is shown as not busy on `fu_busy`, and the buffer presents only entries whose unit is free.

Top module: `oib_issue_buffer`

## Requirements
- R1: The buffer holds at most 4 operations, and `in_ready` is low whenever 4 are held at the start of the cycle, even if one issues in that cycle.
- R2: `in_ready` is low while `in_dst` equals `src1` or `src2` of any buffered operation. An operation that has issued no longer blocks insertion.
- R3: `in_ready` is low while `in_dst` has a pending write. A write is pending from the edge at which its operation is inserted until writeback of that register, whether the operation is buffered or already issued.
- R4: A buffered entry is eligible when each source either has no pending write or equals the entry's own destination, and bit `fu` of `fu_busy` is 0 (unit codes 0 to 3 map to `fu_busy` bits 0 to 3).
- R5: `dsp_valid` is high exactly when some entry is eligible. The outputs then show the oldest eligible entry in insertion order, and that entry leaves the buffer at the next rising edge. At most one entry issues per cycle.
- R6: A writeback (`wb_valid` high) clears the pending bit of `wb_dst` at the edge. Entries waiting on that register can become eligible, and insertion to that register can be accepted, from the next cycle.
- R7: After reset the buffer is empty and no register is pending: `dsp_valid` is 0 and `in_ready` is 1 for any `in_dst`.
- R8: An operation inserted at an edge is first offered for dispatch in the cycle that follows, never in the cycle of its insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decode offers an operation |
| in_ready | output | 1 | Buffer accepts the offered operation |
| in_fu | input | 2 | Target functional unit code |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| fu_busy | input | 4 | One bit per functional unit, 1 = cannot accept |
| dsp_valid | output | 1 | An operation is issued this cycle |
| dsp_fu | output | 2 | Unit code of the issued operation |
| dsp_dst | output | 4 | Destination of the issued operation |
| dsp_src1 | output | 4 | First source of the issued operation |
| dsp_src2 | output | 4 | Second source of the issued operation |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_dst | input | 4 | Register written back |

## Verification
Some properties hold on every cycle and are checked by the assertions. Occupancy never exceeds four and moves by exactly the inserts minus the issues. No accepted operation targets a pending register. Every issued operation has clear sources (or sources equal to its own destination) and a free unit. At most one entry is granted. Writeback always clears its register and insertion always sets its destination. Other behaviour depends on the sequence of operations and only the bench scenarios can show it. That covers which entry wins once the oldest is blocked, the one-cycle delay after insertion and after writeback, and the release of a write-after-read block once the reading entry issues. It also covers the sweeps over every register and over every unit-busy mask.

// File: rtl/oib_pkg.sv
package oib_pkg;
  localparam int REG_W = 4;
  localparam int FU_W  = 2;
  localparam int NREG  = 1 << REG_W;
  localparam int NFU   = 1 << FU_W;

  typedef struct packed {
    logic [FU_W-1:0]  fu;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
  } oib_op_t;
endpackage

// File: rtl/oib_pend_track.sv
module oib_pend_track
  import oib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  output logic [NREG-1:0]  pend
);
  logic [NREG-1:0] pend_q, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_en) set_vec[set_reg] = 1'b1;
    if (clr_en) clr_vec[clr_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  assign pend = pend_q;

  AST_WB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> !pend_q[$past(clr_reg)]); // R6
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_reg)]); // R3
endmodule

// File: rtl/oib_hazard_check.sv
module oib_hazard_check
  import oib_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  oib_op_t [DEPTH-1:0] ops,
  input  logic [DEPTH-1:0]    vld,
  input  logic [NREG-1:0]     pend,
  input  logic                has_space,
  input  logic [REG_W-1:0]    new_dst,
  output logic                ins_ok
);
  logic [DEPTH-1:0] war_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_war
    assign war_vec[i] = vld[i] && (ops[i].src1 == new_dst || ops[i].src2 == new_dst);
  end

  assign ins_ok = has_space && !(|war_vec) && !pend[new_dst];
endmodule

// File: rtl/oib_select.sv
module oib_select
  import oib_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  oib_op_t [DEPTH-1:0] ops,
  input  logic [DEPTH-1:0]    vld,
  input  logic [NREG-1:0]     pend,
  input  logic [NFU-1:0]      fu_busy,
  output logic                any,
  output logic [IW-1:0]       idx
);
  logic [DEPTH-1:0] elig, grant;

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    assign elig[i] = vld[i]
                  && (!pend[ops[i].src1] || ops[i].src1 == ops[i].dst)
                  && (!pend[ops[i].src2] || ops[i].src2 == ops[i].dst)
                  && !fu_busy[ops[i].fu];
  end

  assign grant = elig & (~elig + DEPTH'(1));
  assign any   = |elig;

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]); // R5
endmodule

// File: rtl/oib_issue_buffer.sv
module oib_issue_buffer
  import oib_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FU_W-1:0]  in_fu,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  input  logic [NFU-1:0]   fu_busy,
  output logic             dsp_valid,
  output logic [FU_W-1:0]  dsp_fu,
  output logic [REG_W-1:0] dsp_dst,
  output logic [REG_W-1:0] dsp_src1,
  output logic [REG_W-1:0] dsp_src2,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_dst
);
  oib_op_t [DEPTH-1:0] q_q, q_n;
  oib_op_t             in_op, sel_op;
  logic [CW-1:0]       cnt_q, cnt_n, cnt_mid;
  logic [DEPTH-1:0]    vld;
  logic [NREG-1:0]     pend;
  logic                has_space, ins_fire, sel_any;
  logic [IW-1:0]       sel_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign vld[i] = CW'(i) < cnt_q;
  end

  assign has_space = cnt_q < CW'(DEPTH);
  assign ins_fire  = in_valid && in_ready;

  always_comb begin
    in_op.fu   = in_fu;
    in_op.dst  = in_dst;
    in_op.src1 = in_src1;
    in_op.src2 = in_src2;
  end

  oib_hazard_check #(.DEPTH(DEPTH)) u_haz (
    .ops(q_q), .vld(vld), .pend(pend), .has_space(has_space),
    .new_dst(in_dst), .ins_ok(in_ready)
  );

  oib_select #(.DEPTH(DEPTH)) u_sel (
    .clk(clk), .rst_n(rst_n), .ops(q_q), .vld(vld), .pend(pend),
    .fu_busy(fu_busy), .any(sel_any), .idx(sel_idx)
  );

  oib_pend_track u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(ins_fire), .set_reg(in_dst),
    .clr_en(wb_valid), .clr_reg(wb_dst),
    .pend(pend)
  );

  // Collapse the queue over the issued slot, then append at the tail.
  always_comb begin
    q_n     = q_q;
    cnt_mid = cnt_q - CW'(sel_any);
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (sel_any && IW'(i) >= sel_idx) q_n[i] = q_q[i + 1];
    end
    for (int j = 0; j < DEPTH; j++) begin
      if (ins_fire && CW'(j) == cnt_mid) q_n[j] = in_op;
    end
    cnt_n = cnt_mid + CW'(ins_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_n;
      cnt_q <= cnt_n;
    end
  end

  assign sel_op    = q_q[sel_idx];
  assign dsp_valid = sel_any;
  assign dsp_fu    = sel_op.fu;
  assign dsp_dst   = sel_op.dst;
  assign dsp_src1  = sel_op.src1;
  assign dsp_src2  = sel_op.src2;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire || sel_any) |=>
      cnt_q == $past(cnt_q) + CW'($past(ins_fire)) - CW'($past(sel_any))); // R1
  AST_WAW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> !pend[in_dst]); // R3
  AST_DSP_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> ((!pend[dsp_src1] || dsp_src1 == dsp_dst)
                && (!pend[dsp_src2] || dsp_src2 == dsp_dst))); // R4
  AST_DSP_FU_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> !fu_busy[dsp_fu]); // R4
endmodule

// File: tb/oib_issue_buffer_tb.sv
`timescale 1ns/1ps
module oib_issue_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_fu = '0;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [3:0] fu_busy = '0;
  logic       dsp_valid;
  logic [1:0] dsp_fu;
  logic [3:0] dsp_dst, dsp_src1, dsp_src2;
  logic       wb_valid = 1'b0;
  logic [3:0] wb_dst = '0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oib_issue_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fu(in_fu), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .fu_busy(fu_busy), .dsp_valid(dsp_valid), .dsp_fu(dsp_fu),
    .dsp_dst(dsp_dst), .dsp_src1(dsp_src1), .dsp_src2(dsp_src2),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    wb_valid = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // Offer one operation for a single cycle and check in_ready first.
  task automatic offer(input int fu, input int dst, input int s1, input int s2,
                       input int exp_rdy, input string rq);
    in_fu = 2'(fu); in_dst = 4'(dst); in_src1 = 4'(s1); in_src2 = 4'(s2);
    in_valid = 1'b1;
    #1;
    chk(rq, int'(in_ready), exp_rdy);
    tick();
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    do_reset();
    in_dst = 4'd9;
    #1;
    chk("R7 ready after reset", int'(in_ready), 1);
    chk("R7 no dispatch after reset", int'(dsp_valid), 0);

    // Directed scenario: units all busy while the buffer fills.
    fu_busy = 4'hF;
    offer(0, 1, 2, 3, 1, "R1 insert A");
    offer(1, 4, 1, 5, 1, "R1 insert B");
    offer(2, 5, 7, 7, 0, "R2 WAR dst5 vs B src2");
    offer(2, 6, 7, 7, 1, "R2 insert C");
    offer(3, 1, 8, 8, 0, "R3 WAW dst1 pending");
    offer(3, 0, 0, 2, 1, "R1 insert D");
    offer(0, 9, 8, 8, 0, "R1 full blocks insert");
    chk("R4 all units busy", int'(dsp_valid), 0);
    fu_busy = 4'h0;
    #1;
    chk("R5 oldest eligible A valid", int'(dsp_valid), 1);
    chk("R5 oldest eligible A dst", int'(dsp_dst), 1);
    in_dst = 4'd9;
    #1;
    chk("R1 full even while issuing", int'(in_ready), 0);
    tick();
    chk("R5 C passes blocked B", int'(dsp_dst), 6);
    chk("R5 C unit", int'(dsp_fu), 2);
    tick();
    chk("R4 D self source eligible", int'(dsp_dst), 0);
    tick();
    chk("R4 B waits on r1", int'(dsp_valid), 0);
    offer(0, 5, 8, 8, 0, "R2 WAR while B buffered");
    wb_valid = 1'b1; wb_dst = 4'd1;
    #1;
    chk("R6 no effect before edge", int'(dsp_valid), 0);
    tick();
    wb_valid = 1'b0;
    chk("R6 B eligible after wb", int'(dsp_valid), 1);
    chk("R6 B dst", int'(dsp_dst), 4);
    fu_busy = 4'b0010;
    #1;
    chk("R4 B unit busy", int'(dsp_valid), 0);
    fu_busy = 4'h0;
    #1;
    chk("R4 B unit free", int'(dsp_fu), 1);
    tick();
    chk("R5 B removed", int'(dsp_valid), 0);
    in_fu = 2'd0; in_dst = 4'd5; in_src1 = 4'd8; in_src2 = 4'd8;
    in_valid = 1'b1;
    #1;
    chk("R2 WAR released after issue", int'(in_ready), 1);
    chk("R8 not offered in insert cycle", int'(dsp_valid), 0);
    tick();
    in_valid = 1'b0;
    chk("R8 offered next cycle", int'(dsp_valid), 1);
    chk("R8 offered dst", int'(dsp_dst), 5);
    tick();
    offer(0, 4, 8, 8, 0, "R3 WAW after issue before wb");
    wb_valid = 1'b1; wb_dst = 4'd4;
    tick();
    wb_valid = 1'b0;
    in_dst = 4'd4;
    #1;
    chk("R6 insert allowed after wb", int'(in_ready), 1);

    // Sweep every register: self-sourced op issues, blocks WAW, wb frees it.
    do_reset();
    for (int r = 0; r < 16; r++) begin
      offer(r % 4, r, r, r, 1, "R3 sweep insert free reg");
      chk("R8 sweep issue valid", int'(dsp_valid), 1);
      chk("R4 sweep issue dst", int'(dsp_dst), r);
      chk("R4 sweep issue unit", int'(dsp_fu), r % 4);
      tick();
      offer(r % 4, r, (r + 1) % 16, (r + 1) % 16, 0, "R3 sweep WAW");
      wb_valid = 1'b1; wb_dst = 4'(r);
      tick();
      wb_valid = 1'b0;
      in_dst = 4'(r);
      #1;
      chk("R6 sweep ready after wb", int'(in_ready), 1);
    end

    // Sweep every busy mask over four ready entries on units 0..3.
    for (int m = 0; m < 16; m++) begin
      do_reset();
      fu_busy = 4'hF;
      for (int i = 0; i < 4; i++) offer(i, 8 + i, 12, 13, 1, "R1 mask sweep fill");
      fu_busy = 4'(m);
      #1;
      begin
        int lo;
        lo = -1;
        for (int b = 3; b >= 0; b--) if (((m >> b) & 1) == 0) lo = b;
        chk("R5 mask sweep valid", int'(dsp_valid), (lo >= 0) ? 1 : 0);
        if (lo >= 0) begin
          chk("R5 mask sweep unit", int'(dsp_fu), lo);
          chk("R5 mask sweep dst", int'(dsp_dst), 8 + lo);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule